// File: doc/BRIEF.md
# CPU Hotplug Command Register Block

This block is a 12-byte little-endian register window through which system firmware manages hot addition and removal of a parameterized number of CPUs. Software first stores a CPU number into a selector register. All later status reads and control writes then act on that one CPU. A command field chooses what the two shared data registers return on reads and what they accept on writes. The choices are the selector itself, the selected CPU's 64-bit architectural identifier, or the two OST (OSPM status) reporting registers.

Each CPU has four flags: enabled, insert pending, remove pending and firmware-eject requested. The platform sets them with per-CPU hot-add and hot-remove request pulses. Software clears them through the control byte. Writing command 0 starts a search. It moves the selector to the lowest-numbered CPU that has an insert or remove event pending, so firmware can find the CPU that needs attention. Initiating an eject emits a one-cycle eject pulse for the selected CPU.

Top module: `cpu_hp_regblk`

## Requirements
- R1: Decoded byte offsets are 0x0 (selector on write, command data 2 on read), 0x4 (status on read, control on write), 0x5 (command field, write only) and 0x8 (command data). Any other offset, including a read of 0x5, returns 0, and writes to those offsets change nothing. Read data is 0 whenever no read is requested.
- R2: While the stored selector is not below N_CPU, every read returns 0. In that state, writes to the control byte, the command field and command data are ignored. Writes to the selector still take effect.
- R3: The selector holds 0 at power-up and is not changed by reset. Reset clears every CPU flag, the command field (to 0), both OST registers, the strobe and the eject outputs.
- R4: A status read returns the selected CPU's flags in these bits: bit0 enabled, bit1 insert pending, bit2 remove pending, bit4 firmware-eject requested. All other bits read 0.
- R5: A control write with bit1 set clears the selected CPU's insert flag. A control write with bit2 set clears its remove flag.
- R6: A control write with bit4 set sets the firmware-eject flag. A control write with bit3 set clears the enabled and firmware-eject flags and produces a one-cycle pulse on that CPU's eject output in the following cycle. Bit3 takes precedence over bit4. At most one eject output is high at any time.
- R7: Under command 0, command data reads the selector value. Writing 0 to the command field moves the selector to the lowest-numbered CPU whose insert or remove flag is set. If no CPU has either flag set, the selector and all flags stay as they were.
- R8: Under command 3, command data reads bits 31:0 and command data 2 reads bits 63:32 of the selected CPU's identifier. Command data 2 reads 0 under any other command. Command data reads 0 under any command other than 0 and 3.
- R9: A command data write under command 1 loads the OST event register. Under command 2 it loads the OST status register, and the strobe is high for exactly the next cycle, when both registers show their new values.
- R10: A hot-add pulse sets the CPU's enabled and insert flags. A hot-remove pulse sets its remove flag. A request arriving in the same cycle as a control write that would clear the same flag leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_i | input | 1 | Register write request |
| io_rd_i | input | 1 | Register read request |
| io_addr_i | input | 4 | Byte offset inside the 12-byte window |
| io_wdata_i | input | 32 | Write data; byte registers use bits 7:0 |
| io_rdata_o | output | 32 | Read data, valid in the cycle of the read request |
| hot_add_i | input | N_CPU | Per-CPU hot-add request pulses |
| hot_rm_i | input | N_CPU | Per-CPU hot-remove request pulses |
| cpu_id_i | input | N_CPU*64 | Per-CPU 64-bit architectural identifier, CPU i at bits 64*i upward |
| ost_event_o | output | 32 | OST event register |
| ost_status_o | output | 32 | OST status register |
| ost_strobe_o | output | 1 | One-cycle pulse after an OST status write |
| eject_o | output | N_CPU | Per-CPU one-cycle eject pulses |

## Verification
The interesting collision is a platform request and a software clear that target the same flag of the same CPU in one cycle. Examples are a hot-add pulse alongside a control write that clears the insert flag, or a hot-add alongside an eject initiation. The bench drives the request and the control write together on the selected CPU. It then reads the status byte through the normal interface and expects the set to have won. A cycle-by-cycle reference model predicts every read, OST value, strobe and eject pulse, including the eject pulse that must still appear when the enabled flag survives.

// File: rtl/cpu_hp_pkg.sv
package cpu_hp_pkg;

    localparam int ID_W = 64;

    localparam logic [3:0] OFS_SEL  = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_CMD  = 4'h5;
    localparam logic [3:0] OFS_DATA = 4'h8;

    localparam logic [7:0] CMD_SCAN   = 8'd0;
    localparam logic [7:0] CMD_OST_EV = 8'd1;
    localparam logic [7:0] CMD_OST_ST = 8'd2;
    localparam logic [7:0] CMD_CPUID  = 8'd3;

    localparam int CTL_CLR_INS = 1;
    localparam int CTL_CLR_RM  = 2;
    localparam int CTL_EJECT   = 3;
    localparam int CTL_FW      = 4;

    typedef struct packed {
        logic sel_wr;
        logic ctl_wr;
        logic cmd_wr;
        logic data_wr;
        logic rd_data2;
        logic rd_stat;
        logic rd_data;
    } acc_t;

    typedef struct packed {
        logic en;
        logic ins;
        logic rm;
        logic fw_ej;
    } cpu_flags_t;

    function automatic logic [7:0] pack_status(cpu_flags_t f);
        logic [7:0] s;
        s    = 8'h00;
        s[0] = f.en;
        s[1] = f.ins;
        s[2] = f.rm;
        s[4] = f.fw_ej;
        return s;
    endfunction

endpackage

// File: rtl/cpu_hp_decode.sv
module cpu_hp_decode
    import cpu_hp_pkg::*;
(
    input  logic       io_wr_i,
    input  logic       io_rd_i,
    input  logic [3:0] io_addr_i,
    input  logic       sel_ok_i,
    output acc_t       acc_o
);
    always_comb begin
        acc_o          = '0;
        acc_o.sel_wr   = io_wr_i && (io_addr_i == OFS_SEL);
        acc_o.ctl_wr   = io_wr_i && sel_ok_i && (io_addr_i == OFS_STAT);
        acc_o.cmd_wr   = io_wr_i && sel_ok_i && (io_addr_i == OFS_CMD);
        acc_o.data_wr  = io_wr_i && sel_ok_i && (io_addr_i == OFS_DATA);
        acc_o.rd_data2 = io_rd_i && sel_ok_i && (io_addr_i == OFS_SEL);
        acc_o.rd_stat  = io_rd_i && sel_ok_i && (io_addr_i == OFS_STAT);
        acc_o.rd_data  = io_rd_i && sel_ok_i && (io_addr_i == OFS_DATA);
    end
endmodule

// File: rtl/cpu_hp_flags.sv
module cpu_hp_flags
    import cpu_hp_pkg::*;
#(
    parameter int N_CPU = 8,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CPU-1:0]       add_req_i,
    input  logic [N_CPU-1:0]       rm_req_i,
    input  logic                   ctl_wr_i,
    input  logic [7:0]             ctl_byte_i,
    input  logic [IDX_W-1:0]       sel_idx_i,
    output cpu_flags_t [N_CPU-1:0] flags_o,
    output logic [N_CPU-1:0]       eject_o
);
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        logic       hit;
        cpu_flags_t cur;
        cpu_flags_t nxt;

        assign hit = ctl_wr_i && (sel_idx_i == IDX_W'(i));
        assign cur = flags_o[i];

        always_comb begin
            nxt = cur;
            if (hit && ctl_byte_i[CTL_CLR_INS]) nxt.ins = 1'b0;
            if (hit && ctl_byte_i[CTL_CLR_RM])  nxt.rm  = 1'b0;
            if (hit && ctl_byte_i[CTL_FW])      nxt.fw_ej = 1'b1;
            if (hit && ctl_byte_i[CTL_EJECT]) begin
                nxt.en    = 1'b0;
                nxt.fw_ej = 1'b0;
            end
            // platform requests win over same-cycle software clears
            if (add_req_i[i]) begin
                nxt.en  = 1'b1;
                nxt.ins = 1'b1;
            end
            if (rm_req_i[i]) nxt.rm = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o[i] <= '0;
                eject_o[i] <= 1'b0;
            end else begin
                flags_o[i] <= nxt;
                eject_o[i] <= hit && ctl_byte_i[CTL_EJECT];
            end
        end

        assert_add_sets_flags_R10: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(add_req_i[i])) |-> (flags_o[i].en && flags_o[i].ins));

        assert_rm_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(rm_req_i[i])) |-> flags_o[i].rm);

        assert_eject_drops_fw_R6: assert property (@(posedge clk) disable iff (rst)
            eject_o[i] |-> !flags_o[i].fw_ej);
    end
endmodule

// File: rtl/cpu_hp_search.sv
module cpu_hp_search #(
    parameter int N_CPU = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_CPU-1:0] pend_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // walk downward so the lowest pending index is the last assignment
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_CPU - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            assert_pick_pending_R7: assert (pend_i[idx_o]);
        end
    end
endmodule

// File: rtl/cpu_hp_regblk.sv
module cpu_hp_regblk
    import cpu_hp_pkg::*;
#(
    parameter int N_CPU = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  io_wr_i,
    input  logic                  io_rd_i,
    input  logic [3:0]            io_addr_i,
    input  logic [31:0]           io_wdata_i,
    output logic [31:0]           io_rdata_o,
    input  logic [N_CPU-1:0]      hot_add_i,
    input  logic [N_CPU-1:0]      hot_rm_i,
    input  logic [N_CPU*ID_W-1:0] cpu_id_i,
    output logic [31:0]           ost_event_o,
    output logic [31:0]           ost_status_o,
    output logic                  ost_strobe_o,
    output logic [N_CPU-1:0]      eject_o
);
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    logic [31:0]            sel_q = '0;
    logic [7:0]             cmd_q;
    logic                   sel_ok;
    logic [IDX_W-1:0]       sel_idx;
    acc_t                   acc;
    cpu_flags_t [N_CPU-1:0] flags;
    logic [N_CPU-1:0]       pend;
    logic                   found;
    logic [IDX_W-1:0]       found_idx;
    cpu_flags_t             sel_flags;
    logic [ID_W-1:0]        sel_id;

    assign sel_ok  = (sel_q < 32'(N_CPU));
    assign sel_idx = sel_q[IDX_W-1:0];

    cpu_hp_decode u_dec (
        .io_wr_i   (io_wr_i),
        .io_rd_i   (io_rd_i),
        .io_addr_i (io_addr_i),
        .sel_ok_i  (sel_ok),
        .acc_o     (acc)
    );

    cpu_hp_flags #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .add_req_i  (hot_add_i),
        .rm_req_i   (hot_rm_i),
        .ctl_wr_i   (acc.ctl_wr),
        .ctl_byte_i (io_wdata_i[7:0]),
        .sel_idx_i  (sel_idx),
        .flags_o    (flags),
        .eject_o    (eject_o)
    );

    always_comb begin
        for (int i = 0; i < N_CPU; i++) pend[i] = flags[i].ins | flags[i].rm;
    end

    cpu_hp_search #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_search (
        .pend_i  (pend),
        .found_o (found),
        .idx_o   (found_idx)
    );

    // selector: power-up value only, reset leaves it alone
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (acc.sel_wr)
                sel_q <= io_wdata_i;
            else if (acc.cmd_wr && io_wdata_i[7:0] == CMD_SCAN && found)
                sel_q <= 32'(found_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q        <= CMD_SCAN;
            ost_event_o  <= '0;
            ost_status_o <= '0;
            ost_strobe_o <= 1'b0;
        end else begin
            ost_strobe_o <= 1'b0;
            if (acc.cmd_wr) cmd_q <= io_wdata_i[7:0];
            if (acc.data_wr && cmd_q == CMD_OST_EV) ost_event_o <= io_wdata_i;
            if (acc.data_wr && cmd_q == CMD_OST_ST) begin
                ost_status_o <= io_wdata_i;
                ost_strobe_o <= 1'b1;
            end
        end
    end

    always_comb begin
        sel_flags = '0;
        sel_id    = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_flags = flags[i];
                sel_id    = cpu_id_i[i*ID_W +: ID_W];
            end
        end
    end

    always_comb begin
        io_rdata_o = '0;
        if (acc.rd_stat)
            io_rdata_o = {24'h0, pack_status(sel_flags)};
        else if (acc.rd_data2 && cmd_q == CMD_CPUID)
            io_rdata_o = sel_id[63:32];
        else if (acc.rd_data && cmd_q == CMD_CPUID)
            io_rdata_o = sel_id[31:0];
        else if (acc.rd_data && cmd_q == CMD_SCAN)
            io_rdata_o = sel_q;
    end

    assert_invalid_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |-> (io_rdata_o == 32'h0));

    assert_one_eject_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eject_o));

    assert_strobe_value_R9: assert property (@(posedge clk) disable iff (rst)
        ost_strobe_o |-> (ost_status_o == $past(io_wdata_i)));

    assert_sel_kept_in_reset_R3: assert property (@(posedge clk)
        $past(rst) |-> $stable(sel_q));
endmodule

// File: tb/cpu_hp_regblk_test.sv
module cpu_hp_regblk_test;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]    io_addr = 4'h0;
    logic [31:0]   io_wdata = '0;
    logic [31:0]   io_rdata;
    logic [N-1:0]  hot_add = '0, hot_rm = '0;
    logic [N*64-1:0] cpu_id;
    logic [31:0]   ost_event, ost_status;
    logic          ost_strobe;
    logic [N-1:0]  eject;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    bit [31:0] m_sel = 0;
    bit [7:0]  m_cmd = 0;
    bit        m_en[N], m_ins[N], m_rm[N], m_fw[N];
    bit [31:0] m_ev = 0, m_st = 0;
    bit        m_strobe = 0;
    bit [N-1:0] m_ej = 0;

    always #2.5 clk = ~clk;

    function automatic bit [63:0] id_of(int i);
        return {32'h5000_0000 | 32'(i), 32'hA0C0_0000 | 32'(i << 4)};
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_id
        assign cpu_id[g*64 +: 64] = id_of(g);
    end

    cpu_hp_regblk #(.N_CPU(N)) uut (
        .clk(clk), .rst(rst), .io_wr_i(io_wr), .io_rd_i(io_rd),
        .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
        .hot_add_i(hot_add), .hot_rm_i(hot_rm), .cpu_id_i(cpu_id),
        .ost_event_o(ost_event), .ost_status_o(ost_status),
        .ost_strobe_o(ost_strobe), .eject_o(eject)
    );

    task automatic chk(string rq, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    function automatic bit [31:0] exp_rdata();
        bit [63:0] id;
        bit ok;
        ok = m_sel < N;
        if (!io_rd || !ok) return 0;
        id = id_of(int'(m_sel));
        case (io_addr)
            4'h0: return (m_cmd == 3) ? id[63:32] : 0;
            4'h4: return {27'h0, m_fw[m_sel], 1'b0, m_rm[m_sel], m_ins[m_sel], m_en[m_sel]};
            4'h8: return (m_cmd == 3) ? id[31:0] : ((m_cmd == 0) ? m_sel : 0);
            default: return 0;
        endcase
    endfunction

    task automatic model_update();
        bit ok;
        ok = m_sel < N;
        m_strobe = 0;
        m_ej = 0;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_en[i] = 0; m_ins[i] = 0; m_rm[i] = 0; m_fw[i] = 0;
            end
            m_cmd = 0; m_ev = 0; m_st = 0;
            return;
        end
        if (io_wr && io_addr == 4'h0) m_sel = io_wdata;
        else if (io_wr && ok && io_addr == 4'h4) begin
            if (io_wdata[1]) m_ins[m_sel] = 0;
            if (io_wdata[2]) m_rm[m_sel] = 0;
            if (io_wdata[4]) m_fw[m_sel] = 1;
            if (io_wdata[3]) begin
                m_en[m_sel] = 0; m_fw[m_sel] = 0; m_ej[m_sel] = 1;
            end
        end else if (io_wr && ok && io_addr == 4'h5) begin
            m_cmd = io_wdata[7:0];
            if (m_cmd == 0) begin
                for (int i = 0; i < N; i++)
                    if (m_ins[i] || m_rm[i]) begin m_sel = i; break; end
            end
        end else if (io_wr && ok && io_addr == 4'h8) begin
            if (m_cmd == 1) m_ev = io_wdata;
            if (m_cmd == 2) begin m_st = io_wdata; m_strobe = 1; end
        end
        for (int i = 0; i < N; i++) begin
            if (hot_add[i]) begin m_en[i] = 1; m_ins[i] = 1; end
            if (hot_rm[i]) m_rm[i] = 1;
        end
    endtask

    task automatic step(string rq, bit w, bit r, bit [3:0] a, bit [31:0] d,
                        bit [N-1:0] ad = '0, bit [N-1:0] rm = '0, bit rs = 0);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
        hot_add = ad; hot_rm = rm; rst = rs;
        #1;
        chk(rq, "rdata", io_rdata, exp_rdata());
        chk("R9", "ost_event", ost_event, m_ev);
        chk("R9", "ost_status", ost_status, m_st);
        chk("R9", "ost_strobe", 32'(ost_strobe), 32'(m_strobe));
        chk("R6", "eject", 32'(eject), 32'(m_ej));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(string rq, bit [3:0] a, bit [31:0] d,
                      bit [N-1:0] ad = '0, bit [N-1:0] rm = '0);
        step(rq, 1, 0, a, d, ad, rm);
    endtask

    task automatic rd(string rq, bit [3:0] a);
        step(rq, 0, 1, a, 0);
    endtask

    task automatic idle(string rq, bit [N-1:0] ad = '0, bit [N-1:0] rm = '0);
        step(rq, 0, 0, 4'h0, 0, ad, rm);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_ins[i] = 0; m_rm[i] = 0; m_fw[i] = 0;
        end
        @(negedge clk);
        // R3 reset state, selector at power-up value
        step("R3", 0, 1, 4'h4, 0, '0, '0, 1);
        step("R3", 0, 1, 4'h8, 0, '0, '0, 1);
        rd("R3", 4'h8);
        rd("R4", 4'h4);

        // R10 hot-add CPU2 and CPU5, hot-remove CPU6
        idle("R10", 8'b0010_0100, 8'b0100_0000);
        // R7 search picks lowest pending CPU
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        rd("R4", 4'h4);
        wr("R5", 4'h4, 32'h02);
        rd("R5", 4'h4);
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        wr("R5", 4'h4, 32'h02);
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        rd("R4", 4'h4);
        wr("R5", 4'h4, 32'h04);
        rd("R5", 4'h4);
        // R7 nothing pending: selector unchanged
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        // R7 lowest wins among CPU1 (remove) and CPU7 (add)
        idle("R7", 8'b1000_0000, 8'b0000_0010);
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        wr("R5", 4'h4, 32'h04);
        wr("R7", 4'h5, 0);
        rd("R7", 4'h8);
        wr("R5", 4'h4, 32'h02);

        // R1 reserved offsets
        wr("R1", 4'h6, 32'hFF);
        wr("R1", 4'hC, 32'hFFFF_FFFF);
        rd("R1", 4'h5);
        rd("R1", 4'h6);
        rd("R1", 4'hC);
        rd("R1", 4'h8);
        rd("R8", 4'h0);
        idle("R1");

        // R8 identifier under command 3
        wr("R8", 4'h0, 5);
        wr("R8", 4'h5, 3);
        rd("R8", 4'h8);
        rd("R8", 4'h0);
        wr("R8", 4'h0, 7);
        rd("R8", 4'h8);
        rd("R8", 4'h0);
        wr("R8", 4'h5, 8'h07);
        rd("R8", 4'h8);
        rd("R8", 4'h0);

        // R9 OST registers and strobe
        wr("R9", 4'h5, 1);
        wr("R9", 4'h8, 32'h0000_1234);
        idle("R9");
        wr("R9", 4'h5, 2);
        wr("R9", 4'h8, 32'hBEEF_0001);
        wr("R9", 4'h8, 32'hBEEF_0002);
        idle("R9");
        idle("R9");

        // R6 firmware eject handover, then eject
        wr("R6", 4'h0, 5);
        wr("R6", 4'h4, 32'h10);
        rd("R6", 4'h4);
        wr("R6", 4'h4, 32'h08);
        rd("R6", 4'h4);
        idle("R6");
        wr("R6", 4'h4, 32'h18);
        rd("R6", 4'h4);

        // R2 out-of-range selector
        wr("R2", 4'h0, 20);
        rd("R2", 4'h4);
        rd("R2", 4'h8);
        rd("R2", 4'h0);
        wr("R2", 4'h4, 32'h10);
        wr("R2", 4'h5, 0);
        wr("R2", 4'h5, 1);
        wr("R2", 4'h8, 32'hDEAD);
        wr("R2", 4'h0, 32'h8000_0000);
        rd("R2", 4'h4);
        wr("R2", 4'h0, 5);
        rd("R2", 4'h4);
        rd("R2", 4'h8);

        // R10 request beats same-cycle clear
        wr("R10", 4'h0, 2);
        wr("R10", 4'h4, 32'h02, 8'b0000_0100);
        rd("R10", 4'h4);
        idle("R10", '0, 8'b0000_0100);
        wr("R10", 4'h4, 32'h04, '0, 8'b0000_0100);
        rd("R10", 4'h4);
        wr("R10", 4'h4, 32'h08, 8'b0000_0100);
        rd("R10", 4'h4);
        idle("R10");

        // R3 selector kept across reset
        wr("R3", 4'h0, 3);
        step("R3", 0, 1, 4'h8, 0, '0, '0, 1);
        step("R3", 0, 0, 4'h0, 0, '0, '0, 1);
        rd("R3", 4'h8);
        rd("R3", 4'h4);
        wr("R3", 4'h0, 2);
        rd("R3", 4'h4);
        idle("R3");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule